// File: doc/BRIEF.md
# Polling SPI Command Master

This block is an SPI master that sends a short command to one attached device and then keeps clocking filler bytes until the device answers. A start strobe begins the work. It takes up to `CMD_BYTES` command bytes, a selectable number of which are sent, and a limit on how many filler bytes it may spend waiting. Each filler byte is all ones on the data-out line. The device is treated as busy while it sends back all-ones. The first reply byte that is not all-ones comes back as the response. If the limit runs out first, a timeout flag is raised instead.

The serial clock idles high and runs only while a byte is on the wire. Data leaves the block most significant bit first. It changes as the clock falls, and the incoming line is sampled as the clock rises. Two 16-bit settings pace the bus. One is the number of system clocks between selecting the device and the first clock edge. The other is the number of system clocks in each half of a serial clock period, which caps the bus rate at what the device can accept. The device is deselected one half-period after the final rising edge. A completion pulse then reports the result byte, the timeout flag and the number of filler bytes used.

Top module: `spi_poll_master`

## Requirements
- R1: While reset is held and after it is released with no start: chip select is high, the serial clock is high, `done` is 0 and `busy` is 0.
- R2: A start strobe taken while idle drives chip select low on the next clock. The first falling serial clock edge follows max(`csDelay`,1) system clocks later. `busy` is high whenever chip select is low.
- R3: Every low phase and every high phase of the serial clock lasts max(`halfDiv`,1) system clocks.
- R4: Command byte i sits in `cmdData[8i+7:8i]`, and bytes go out in order of i, starting at byte 0. Each byte is sent most significant bit first. The data-out line changes only on falling serial clock edges.
- R5: The incoming line is sampled on each rising serial clock edge. The first sampled bit becomes bit 7 of the received byte.
- R6: After the last command byte, the data-out line carries 0xFF bytes. Replies received during the command bytes are discarded even when they are not 0xFF.
- R7: The first filler-phase reply that is not 0xFF is returned in `respByte` with `timeout`=0. `pollCount` then equals the number of filler bytes clocked, including the answering byte.
- R8: With `pollLimit`=N>0 and N busy replies in a row, exactly N filler bytes are clocked. The block then finishes with `timeout`=1, `respByte`=0xFF and `pollCount`=N.
- R9: With `pollLimit`=0, no filler byte is clocked. The block finishes after the command with `timeout`=1, `respByte`=0xFF and `pollCount`=0.
- R10: `done` is high for exactly one cycle. Chip select rises in that same cycle, max(`halfDiv`,1) system clocks after the last rising serial clock edge.
- R11: The serial clock never changes while chip select is high. A start strobe that arrives while `busy` is high has no effect.
- R12: A `cmdLen` of 0 sends one command byte. A value above `CMD_BYTES` sends `CMD_BYTES` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a command and poll sequence (taken only when idle) |
| cmdLen | input | $clog2(CMD_BYTES+1) | Number of command bytes to send |
| cmdData | input | 8*CMD_BYTES | Command bytes, byte 0 in the low eight bits |
| halfDiv | input | DIV_W | System clocks per serial clock half-period (0 acts as 1) |
| csDelay | input | DIV_W | System clocks from select to first clock edge (0 acts as 1) |
| pollLimit | input | LIMIT_W | Maximum number of filler bytes |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| respByte | output | 8 | Returned response, 0xFF on timeout |
| timeout | output | 1 | The poll limit was reached with no answer |
| pollCount | output | LIMIT_W | Filler bytes clocked in the last sequence |
| spiCsN | output | 1 | Chip select, active low |
| spiSck | output | 1 | Serial clock, idles high |
| spiMosi | output | 1 | Serial data to the device |
| spiMiso | input | 1 | Serial data from the device |

## Verification
The bench targets an answer that arrives on exactly the last allowed filler byte. A design with an off-by-one limit compare would report a timeout there, or clock one byte too many. Command-phase replies that are not 0xFF check that replies are ignored until the command is finished. A design that polled too early would return a command echo as its response. The runs also cover a zero poll limit, zero divider and delay settings, an empty command length, and a second start strobe during a transfer. Wrong handling of these would show up as an extra byte on the bus, a serial clock running faster than one system clock per phase, or a second sequence that was never asked for.

// File: rtl/spi_poll_pkg.sv
package spi_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } ctlState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic startXfer;
    logic loadTimer;
    logic sample;
    logic nextBit;
    logic loadCmd;
    logic loadPoll;
    logic bumpPoll;
    logic finishOk;
    logic finishTimeout;
  } dpCtl_t;

endpackage

// File: rtl/spi_poll_dp.sv
module spi_poll_dp
  import spi_poll_pkg::*;
#(
  parameter int CMD_BYTES = 4,
  parameter int DIV_W     = 16,
  parameter int LIMIT_W   = 8,
  localparam int IDX_W    = $clog2(CMD_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtl_t                 ctl,
  input  logic [IDX_W-1:0]       cmdLen,
  input  logic [8*CMD_BYTES-1:0] cmdData,
  input  logic [DIV_W-1:0]       halfDiv,
  input  logic [DIV_W-1:0]       csDelay,
  input  logic [LIMIT_W-1:0]     pollLimit,
  input  logic                   spiMiso,
  output logic                   timerZero,
  output logic                   lastBit,
  output logic                   cmdDone,
  output logic                   rxBusy,
  output logic                   pollLast,
  output logic                   limitZero,
  output logic                   txBit,
  output logic [7:0]             respByte,
  output logic                   timeoutFlag,
  output logic [LIMIT_W-1:0]     pollCount
);

  logic [DIV_W-1:0]   timer;
  logic [DIV_W-1:0]   halfEff;
  logic [DIV_W-1:0]   setupEff;
  logic [IDX_W-1:0]   effLen;
  logic [IDX_W-1:0]   byteIdx;
  logic [2:0]         bitCnt;
  logic [7:0]         txShift;
  logic [7:0]         rxShift;
  logic [7:0]         nextCmdByte;
  logic [LIMIT_W-1:0] pollCnt;
  logic [LIMIT_W:0]   pollNext;

  assign halfEff  = (halfDiv == '0) ? DIV_W'(1) : halfDiv;
  assign setupEff = (csDelay == '0) ? DIV_W'(1) : csDelay;

  always_comb begin
    if (cmdLen == '0)                    effLen = IDX_W'(1);
    else if (cmdLen > IDX_W'(CMD_BYTES)) effLen = IDX_W'(CMD_BYTES);
    else                                 effLen = cmdLen;
  end

  always_comb begin
    nextCmdByte = 8'h00;
    for (int i = 0; i < CMD_BYTES; i++)
      if (byteIdx == IDX_W'(i)) nextCmdByte = cmdData[8*i +: 8];
  end

  assign pollNext  = {1'b0, pollCnt} + (LIMIT_W+1)'(1);
  assign timerZero = (timer == '0);
  assign lastBit   = (bitCnt == 3'd7);
  assign cmdDone   = (byteIdx >= effLen);
  assign rxBusy    = (rxShift == 8'hFF);
  assign pollLast  = (pollNext >= {1'b0, pollLimit});
  assign limitZero = (pollLimit == '0);
  assign txBit     = txShift[7];
  assign pollCount = pollCnt;

  // one shared down-counter paces both the select setup and every clock phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timer <= '0;
    else if (ctl.startXfer) timer <= setupEff - DIV_W'(1);
    else if (ctl.loadTimer) timer <= halfEff - DIV_W'(1);
    else if (!timerZero)    timer <= timer - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= 8'hFF;
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (ctl.startXfer) begin
      txShift <= cmdData[7:0];
      bitCnt  <= '0;
      byteIdx <= IDX_W'(1);
    end else if (ctl.loadCmd) begin
      txShift <= nextCmdByte;
      bitCnt  <= '0;
      byteIdx <= byteIdx + IDX_W'(1);
    end else if (ctl.loadPoll) begin
      txShift <= 8'hFF;
      bitCnt  <= '0;
    end else if (ctl.nextBit) begin
      txShift <= {txShift[6:0], 1'b1};
      bitCnt  <= bitCnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxShift <= '0;
    else if (ctl.sample) rxShift <= {rxShift[6:0], spiMiso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pollCnt <= '0;
    else if (ctl.startXfer) pollCnt <= '0;
    else if (ctl.bumpPoll)  pollCnt <= pollNext[LIMIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respByte    <= 8'hFF;
      timeoutFlag <= 1'b0;
    end else if (ctl.finishOk) begin
      respByte    <= rxShift;
      timeoutFlag <= 1'b0;
    end else if (ctl.finishTimeout) begin
      respByte    <= 8'hFF;
      timeoutFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_poll_ctl.sv
module spi_poll_ctl
  import spi_poll_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      timerZero,
  input  logic      lastBit,
  input  logic      cmdDone,
  input  logic      rxBusy,
  input  logic      pollLast,
  input  logic      limitZero,
  output dpCtl_t    ctl,
  output ctlState_t state
);

  ctlState_t nxt;
  logic      inCmd;

  always_comb begin
    ctl = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.startXfer = 1'b1;
        nxt = ST_SETUP;
      end
      ST_SETUP: if (timerZero) begin
        ctl.loadTimer = 1'b1;
        nxt = ST_LOW;
      end
      ST_LOW: if (timerZero) begin
        ctl.sample    = 1'b1;
        ctl.loadTimer = 1'b1;
        nxt = ST_HIGH;
      end
      ST_HIGH: if (timerZero) begin
        if (!lastBit) begin
          ctl.nextBit   = 1'b1;
          ctl.loadTimer = 1'b1;
          nxt = ST_LOW;
        end else if (inCmd) begin
          if (!cmdDone) begin
            ctl.loadCmd   = 1'b1;
            ctl.loadTimer = 1'b1;
            nxt = ST_LOW;
          end else if (limitZero) begin
            ctl.finishTimeout = 1'b1;
            nxt = ST_DONE;
          end else begin
            ctl.loadPoll  = 1'b1;
            ctl.loadTimer = 1'b1;
            nxt = ST_LOW;
          end
        end else begin
          ctl.bumpPoll = 1'b1;
          if (!rxBusy) begin
            ctl.finishOk = 1'b1;
            nxt = ST_DONE;
          end else if (pollLast) begin
            ctl.finishTimeout = 1'b1;
            nxt = ST_DONE;
          end else begin
            ctl.loadPoll  = 1'b1;
            ctl.loadTimer = 1'b1;
            nxt = ST_LOW;
          end
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      inCmd <= 1'b0;
    end else begin
      state <= nxt;
      if (ctl.startXfer)     inCmd <= 1'b1;
      else if (ctl.loadPoll) inCmd <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_poll_master.sv
module spi_poll_master
  import spi_poll_pkg::*;
#(
  parameter int CMD_BYTES = 4,
  parameter int DIV_W     = 16,
  parameter int LIMIT_W   = 8,
  localparam int IDX_W    = $clog2(CMD_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [IDX_W-1:0]       cmdLen,
  input  logic [8*CMD_BYTES-1:0] cmdData,
  input  logic [DIV_W-1:0]       halfDiv,
  input  logic [DIV_W-1:0]       csDelay,
  input  logic [LIMIT_W-1:0]     pollLimit,
  output logic                   busy,
  output logic                   done,
  output logic [7:0]             respByte,
  output logic                   timeout,
  output logic [LIMIT_W-1:0]     pollCount,
  output logic                   spiCsN,
  output logic                   spiSck,
  output logic                   spiMosi,
  input  logic                   spiMiso
);

  dpCtl_t    ctl;
  ctlState_t state;
  logic      timerZero, lastBit, cmdDone, rxBusy, pollLast, limitZero, txBit;

  spi_poll_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .timerZero (timerZero),
    .lastBit   (lastBit),
    .cmdDone   (cmdDone),
    .rxBusy    (rxBusy),
    .pollLast  (pollLast),
    .limitZero (limitZero),
    .ctl       (ctl),
    .state     (state)
  );

  spi_poll_dp #(
    .CMD_BYTES (CMD_BYTES),
    .DIV_W     (DIV_W),
    .LIMIT_W   (LIMIT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cmdLen      (cmdLen),
    .cmdData     (cmdData),
    .halfDiv     (halfDiv),
    .csDelay     (csDelay),
    .pollLimit   (pollLimit),
    .spiMiso     (spiMiso),
    .timerZero   (timerZero),
    .lastBit     (lastBit),
    .cmdDone     (cmdDone),
    .rxBusy      (rxBusy),
    .pollLast    (pollLast),
    .limitZero   (limitZero),
    .txBit       (txBit),
    .respByte    (respByte),
    .timeoutFlag (timeout),
    .pollCount   (pollCount)
  );

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign spiCsN  = (state == ST_IDLE) || (state == ST_DONE);
  assign spiSck  = (state != ST_LOW);
  assign spiMosi = txBit;

endmodule

// File: rtl/spi_poll_master_chk.sv
module spi_poll_master_chk #(
  parameter int DIV_W   = 16,
  parameter int LIMIT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [DIV_W-1:0]   halfDiv,
  input logic [LIMIT_W-1:0] pollLimit,
  input logic               busy,
  input logic               done,
  input logic [7:0]         respByte,
  input logic               timeout,
  input logic [LIMIT_W-1:0] pollCount,
  input logic               spiCsN,
  input logic               spiSck
);

  logic [DIV_W:0] lowCnt;
  logic [DIV_W:0] effHalf;

  assign effHalf = (halfDiv == '0) ? (DIV_W+1)'(1) : {1'b0, halfDiv};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       lowCnt <= '0;
    else if (spiSck) lowCnt <= '0;
    else             lowCnt <= lowCnt + (DIV_W+1)'(1);
  end

  AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> busy); // R2
  AST_LOW_PHASE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && $rose(spiSck)) |-> (lowCnt == effHalf)); // R3
  AST_ANSWER_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (done && !timeout) |-> (respByte != 8'hFF)); // R7
  AST_TIMEOUT_RESP: assert property (@(posedge clk) disable iff (!rstN)
    (done && timeout) |-> (respByte == 8'hFF)); // R8
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pollCount <= pollLimit)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> spiCsN); // R10
  AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> done); // R10
  AST_SCK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> spiSck); // R11

endmodule

bind spi_poll_master spi_poll_master_chk #(
  .DIV_W   (DIV_W),
  .LIMIT_W (LIMIT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .halfDiv   (halfDiv),
  .pollLimit (pollLimit),
  .busy      (busy),
  .done      (done),
  .respByte  (respByte),
  .timeout   (timeout),
  .pollCount (pollCount),
  .spiCsN    (spiCsN),
  .spiSck    (spiSck)
);

// File: tb/spi_poll_master_tb.sv
module spi_poll_master_tb;

  localparam int CLK_PERIOD = 10;
  localparam int K  = 4;
  localparam int NV = 5;

  // vector table: length, command, half-period, setup delay, limit, busy replies, status
  localparam logic [2:0]  V_LEN  [NV] = '{3'd1, 3'd4, 3'd2, 3'd3, 3'd1};
  localparam logic [31:0] V_CMD  [NV] = '{32'h00000040, 32'h44332211, 32'h00000158,
                                          32'h00C3B2A1, 32'h0000007E};
  localparam logic [15:0] V_HALF [NV] = '{16'd1, 16'd2, 16'd3, 16'd1, 16'd0};
  localparam logic [15:0] V_DLY  [NV] = '{16'd1, 16'd3, 16'd5, 16'd2, 16'd0};
  localparam logic [7:0]  V_LIM  [NV] = '{8'd8, 8'd10, 8'd4, 8'd3, 8'd2};
  localparam int          V_BUSY [NV] = '{0, 3, 3, 5, 1};
  localparam logic [7:0]  V_STAT [NV] = '{8'h00, 8'h05, 8'hFE, 8'h01, 8'h7F};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cmdLen = '0;
  logic [31:0] cmdData = '0;
  logic [15:0] halfDiv = 16'd1;
  logic [15:0] csDelay = 16'd1;
  logic [7:0]  pollLimit = '0;
  logic        busy, done, timeout, spiCsN, spiSck, spiMosi;
  logic        spiMiso = 1'b1;
  logic [7:0]  respByte, pollCount;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_poll_master u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdLen(cmdLen), .cmdData(cmdData),
    .halfDiv(halfDiv), .csDelay(csDelay), .pollLimit(pollLimit), .busy(busy),
    .done(done), .respByte(respByte), .timeout(timeout), .pollCount(pollCount),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // device model
  int         cfgCmdN, cfgBusyN;
  logic [7:0] cfgStatus;
  int         slvBit, slvByte;
  logic [7:0] slvIn;
  logic [7:0] seen [64];

  function automatic logic [7:0] replyFor(int idx);
    if (idx < cfgCmdN) return 8'hA5 ^ 8'(idx);
    if (idx - cfgCmdN < cfgBusyN) return 8'hFF;
    return cfgStatus;
  endfunction

  always @(negedge spiSck) if (spiCsN === 1'b0) begin
    logic [7:0] r;
    r = replyFor(slvByte);
    spiMiso = r[7 - slvBit];
  end

  always @(posedge spiSck) if (spiCsN === 1'b0) begin
    slvIn = {slvIn[6:0], spiMosi};
    slvBit++;
    if (slvBit == 8) begin
      if (slvByte < 64) seen[slvByte] = slvIn;
      slvByte++;
      slvBit = 0;
    end
  end

  // timing monitors
  time tCsFall, tFirstFall, tFall, tLastRise, tCsRise;
  bit  firstFallSeen;
  int  minLow, maxLow, minHigh, maxHigh, stray;

  always @(negedge spiCsN) tCsFall = $time;
  always @(posedge spiCsN) tCsRise = $time;
  always @(negedge spiSck) if (spiCsN === 1'b0) begin
    if (!firstFallSeen) begin
      tFirstFall = $time;
      firstFallSeen = 1;
    end else begin
      int w;
      w = int'(($time - tLastRise) / CLK_PERIOD);
      if (w < minHigh) minHigh = w;
      if (w > maxHigh) maxHigh = w;
    end
    tFall = $time;
  end
  always @(posedge spiSck) if (spiCsN === 1'b0) begin
    int w;
    w = int'(($time - tFall) / CLK_PERIOD);
    if (w < minLow) minLow = w;
    if (w > maxLow) maxLow = w;
    tLastRise = $time;
  end
  always @(spiSck) if (rstN && spiCsN === 1'b1) stray++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      summary();
    end
  end

  task automatic runCase(input logic [2:0] len, input logic [31:0] cmd,
                         input logic [15:0] half, input logic [15:0] dly,
                         input logic [7:0] lim, input int busyN,
                         input logic [7:0] status, input bit dbl);
    int effLen, h, d, expPoll, expTo, guard, doneCnt, busyAfter;
    logic [7:0] expResp, gotResp;
    logic gotTo, gotCs;
    int gotPoll;
    effLen = (len == 0) ? 1 : ((len > K) ? K : int'(len));
    h = (half == 0) ? 1 : int'(half);
    d = (dly == 0) ? 1 : int'(dly);
    if (lim == 0) begin
      expPoll = 0; expTo = 1; expResp = 8'hFF;
    end else if (busyN < int'(lim)) begin
      expPoll = busyN + 1; expTo = 0; expResp = status;
    end else begin
      expPoll = int'(lim); expTo = 1; expResp = 8'hFF;
    end
    cfgCmdN = effLen; cfgBusyN = busyN; cfgStatus = status;
    slvBit = 0; slvByte = 0; firstFallSeen = 0;
    minLow = 1 << 30; maxLow = 0; minHigh = 1 << 30; maxHigh = 0; stray = 0;
    @(negedge clk);
    cmdLen = len; cmdData = cmd; halfDiv = half; csDelay = dly; pollLimit = lim;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dbl) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done !== 1'b1 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    gotResp = respByte; gotTo = timeout; gotPoll = int'(pollCount); gotCs = spiCsN;
    chk(done === 1'b1, "R10 done seen", int'(done), 1);
    chk(gotResp == expResp, "R5 R7 R8 respByte", int'(gotResp), int'(expResp));
    chk(gotTo == expTo[0], "R7 R8 R9 timeout", int'(gotTo), expTo);
    chk(gotPoll == expPoll, "R7 R8 R9 pollCount", gotPoll, expPoll);
    chk(gotCs == 1'b1, "R10 select released with done", int'(gotCs), 1);
    chk(int'((tCsRise - tLastRise) / CLK_PERIOD) == h, "R10 release delay",
        int'((tCsRise - tLastRise) / CLK_PERIOD), h);
    doneCnt = 1;
    busyAfter = 0;
    repeat (6) begin
      @(negedge clk);
      if (done === 1'b1) doneCnt++;
      if (busy === 1'b1) busyAfter++;
    end
    chk(doneCnt == 1, "R10 R11 single done pulse", doneCnt, 1);
    chk(busyAfter == 0, "R11 no extra sequence", busyAfter, 0);
    chk(int'((tFirstFall - tCsFall) / CLK_PERIOD) == d, "R2 select to first edge",
        int'((tFirstFall - tCsFall) / CLK_PERIOD), d);
    chk(minLow == h && maxLow == h, "R3 low phase", maxLow, h);
    chk(minHigh == h && maxHigh == h, "R3 high phase", maxHigh, h);
    chk(slvByte == effLen + expPoll, "R4 R6 R12 byte count", slvByte, effLen + expPoll);
    for (int i = 0; i < effLen + expPoll && i < 64; i++) begin
      logic [7:0] want;
      want = (i < effLen) ? cmd[8*i +: 8] : 8'hFF;
      chk(seen[i] == want, (i < effLen) ? "R4 command byte" : "R6 filler byte",
          int'(seen[i]), int'(want));
    end
    chk(stray == 0, "R11 clock quiet while deselected", stray, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spiCsN === 1'b1 && spiSck === 1'b1, "R1 lines in reset", int'({spiCsN, spiSck}), 3);
    chk(done === 1'b0 && busy === 1'b0, "R1 status in reset", int'({done, busy}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(spiCsN === 1'b1 && spiSck === 1'b1 && busy === 1'b0, "R1 idle after reset",
        int'({spiCsN, spiSck, busy}), 6);

    for (int v = 0; v < NV; v++)
      runCase(V_LEN[v], V_CMD[v], V_HALF[v], V_DLY[v], V_LIM[v], V_BUSY[v], V_STAT[v], 1'b0);

    // R9: zero limit, no filler bytes
    runCase(3'd2, 32'h00009A33, 16'd2, 16'd1, 8'd0, 0, 8'h10, 1'b0);
    // R12: empty and oversized command lengths
    runCase(3'd0, 32'hDDCCBB6C, 16'd1, 16'd1, 8'd5, 2, 8'h22, 1'b0);
    runCase(3'd7, 32'h87654321, 16'd1, 16'd1, 8'd5, 1, 8'h44, 1'b0);
    // R11: second start during a transfer
    runCase(3'd2, 32'h00005A5A, 16'd2, 16'd2, 8'd6, 2, 8'h30, 1'b1);

    // R7: random busy lengths
    for (int r = 0; r < 4; r++) begin
      int b;
      logic [7:0] st;
      b = int'($urandom_range(0, 9));
      st = 8'($urandom_range(0, 254));
      runCase(3'd3, $urandom, 16'($urandom_range(1, 3)), 16'($urandom_range(1, 4)),
              8'd10, b, st, 1'b0);
    end
    summary();
  end

endmodule